// File: doc/BRIEF.md
# Navigation Key Event Port

This block turns the already-debounced levels of five navigation keys into press events and presents them to a small soft processor as one readable byte on its input port. Each key is watched for a rising edge. When one or more keys go from released to pressed, the block records which keys rose and raises a sticky "active" flag. Keeping a key held down produces no further events.

Software polls the byte by reading the block's port address. That read clears the active flag but keeps the recorded key pattern. As an alternative to polling, the block can raise an interrupt request on every new press. The request stays high until the processor acknowledges it, and the acknowledge also clears the active flag. When a new press arrives in the same cycle as a clearing read or an acknowledge, the press takes priority.

Top module: `keypad_event_port`

## Requirements
- R1: While reset is high and the cycle after reset, the port byte at the block's address reads 0x00 and intReq is low.
- R2: A rising edge on any keyLevel bit sets bit 7 (active) of the port byte and loads bits 4..0 with the mask of keys that rose that cycle (bit 4 Select, bit 3 Right, bit 2 Left, bit 1 Up, bit 0 Down). The new value is visible after the next clock edge.
- R3: A key that stays held produces exactly one event, so once active is cleared it stays clear while the key remains held.
- R4: A clock edge with readStrobe high and portId equal to PORT_ADDR clears the active bit and leaves bits 4..0 unchanged.
- R5: A clock edge with intAck high clears the active bit.
- R6: When a new press coincides with a clearing read or an acknowledge, the active bit ends up set.
- R7: Bits 6..5 of the port byte always read zero, and readData is 0x00 whenever portId differs from PORT_ADDR.
- R8: With interrupts enabled, intReq goes high together with the active bit on a press and stays high through reads until an edge with intAck high drops it.
- R9: A key held high through reset produces no event when reset is released.
- R10: Bits 4..0 keep the most recent press mask until the next press, regardless of key releases, reads or acknowledges. A read strobe at any other port address changes nothing.
- R11: A press arriving in the same cycle as intAck leaves intReq high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| keyLevel | input | 5 | Debounced key levels, 1 = pressed (4 Select, 3 Right, 2 Left, 1 Up, 0 Down) |
| portId | input | 8 | Processor port address |
| readStrobe | input | 1 | Processor input-port read strobe |
| intAck | input | 1 | Processor interrupt acknowledge |
| readData | output | 8 | Port byte: active flag, two zero bits, key mask |
| intReq | output | 1 | Interrupt request |

## Verification
The assertions assume that key levels, portId and the strobes are stable around the clock edge and that readStrobe and intAck are single-cycle pulses. They make no assumption about how often presses, reads and acknowledges coincide. The stimulus changes every input only on the falling edge. It keeps presses sparse enough that reads and acknowledges often land on an idle flag. It also forces the collisions on purpose: a press together with a read, a press together with an acknowledge, and a key held through reset. Read strobes alternate between the block's address and other addresses.

// File: rtl/keyev_pkg.sv
package keyev_pkg;
  // Key bit positions within the captured mask; software decodes these.
  localparam int KEY_DOWN   = 0;
  localparam int KEY_UP     = 1;
  localparam int KEY_LEFT   = 2;
  localparam int KEY_RIGHT  = 3;
  localparam int KEY_SELECT = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadKeys;   // capture the rise mask this cycle
    logic showByte;   // portId addresses this block
  } keyevStrobes_t;
endpackage

// File: rtl/keyev_datapath.sv
module keyev_datapath
  import keyev_pkg::*;
#(
  parameter int NUM_KEYS = 5,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keyLevel,
  input  keyevStrobes_t       strb,
  input  logic                activeFlag,
  output logic                anyRise,
  output logic [DATA_W-1:0]   readData
);
  localparam int ACTIVE_POS = DATA_W - 1;

  logic [NUM_KEYS-1:0] keyPrev;
  logic [NUM_KEYS-1:0] riseMask;
  logic [NUM_KEYS-1:0] keyBits;

  // Per-key rising edge detector. History resets to "pressed" so a key
  // held through reset does not count as a new press.
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst) keyPrev[k] <= 1'b1;
      else     keyPrev[k] <= keyLevel[k];
    end
    assign riseMask[k] = keyLevel[k] & ~keyPrev[k];
  end

  assign anyRise = |riseMask;

  always_ff @(posedge clk) begin
    if (rst)                keyBits <= '0;
    else if (strb.loadKeys) keyBits <= riseMask;
  end

  always_comb begin
    readData = '0;
    if (strb.showByte) begin
      readData[NUM_KEYS-1:0] = keyBits;
      readData[ACTIVE_POS]   = activeFlag;
    end
  end

  // R10
  keybits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.loadKeys |=> $stable(keyBits));

  // R2
  load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    strb.loadKeys |=> (keyBits != '0));
endmodule

// File: rtl/keyev_ctrl.sv
module keyev_ctrl
  import keyev_pkg::*;
#(
  parameter int          ID_W       = 8,
  parameter int unsigned PORT_ADDR  = 0,
  parameter bit          IRQ_ENABLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            anyRise,
  input  logic [ID_W-1:0] portId,
  input  logic            readStrobe,
  input  logic            intAck,
  output keyevStrobes_t   strb,
  output logic            activeFlag,
  output logic            intReq
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(PORT_ADDR);

  logic addrHit;
  logic clearReq;

  assign addrHit  = (portId == MY_ID);
  assign clearReq = (readStrobe & addrHit) | intAck;

  assign strb.loadKeys = anyRise;
  assign strb.showByte = addrHit;

  // A new press takes priority over any clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)           activeFlag <= 1'b0;
    else if (anyRise)  activeFlag <= 1'b1;
    else if (clearReq) activeFlag <= 1'b0;
  end

  if (IRQ_ENABLE) begin : g_irq
    logic irqFlag;
    always_ff @(posedge clk) begin
      if (rst)          irqFlag <= 1'b0;
      else if (anyRise) irqFlag <= 1'b1;
      else if (intAck)  irqFlag <= 1'b0;
    end
    assign intReq = irqFlag;

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (intReq && !intAck) |=> intReq);

    // R11
    irq_press_wins_chk: assert property (@(posedge clk) disable iff (rst)
      anyRise |=> intReq);
  end else begin : g_noirq
    assign intReq = 1'b0;
  end

  // R6
  press_wins_chk: assert property (@(posedge clk) disable iff (rst)
    anyRise |=> activeFlag);

  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (readStrobe && addrHit && !anyRise) |=> !activeFlag);

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (intAck && !anyRise) |=> !activeFlag);

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!activeFlag && !anyRise) |=> !activeFlag);
endmodule

// File: rtl/keypad_event_port.sv
module keypad_event_port
  import keyev_pkg::*;
#(
  parameter int          NUM_KEYS   = 5,
  parameter int          DATA_W     = 8,
  parameter int          ID_W       = 8,
  parameter int unsigned PORT_ADDR  = 8'h20,
  parameter bit          IRQ_ENABLE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keyLevel,
  input  logic [ID_W-1:0]     portId,
  input  logic                readStrobe,
  input  logic                intAck,
  output logic [DATA_W-1:0]   readData,
  output logic                intReq
);
  keyevStrobes_t strb;
  logic          anyRise;
  logic          activeFlag;

  keyev_ctrl #(
    .ID_W(ID_W), .PORT_ADDR(PORT_ADDR), .IRQ_ENABLE(IRQ_ENABLE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .anyRise(anyRise), .portId(portId),
    .readStrobe(readStrobe), .intAck(intAck), .strb(strb),
    .activeFlag(activeFlag), .intReq(intReq)
  );

  keyev_datapath #(
    .NUM_KEYS(NUM_KEYS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .keyLevel(keyLevel), .strb(strb),
    .activeFlag(activeFlag), .anyRise(anyRise), .readData(readData)
  );

  // R7
  gap_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    readData[DATA_W-2:NUM_KEYS] == '0);
endmodule

// File: tb/sim_keypad_event_port.sv
module sim_keypad_event_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ADDR = 8'h20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] keyLevel = '0;
  logic [7:0] portId = '0;
  logic       readStrobe = 1'b0;
  logic       intAck = 1'b0;
  logic [7:0] readData;
  logic       intReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  logic [4:0] mPrev = '1;
  logic [4:0] mKeys = '0;
  logic       mAct  = 1'b0;
  logic       mIrq  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_event_port u0 (
    .clk(clk), .rst(rst), .keyLevel(keyLevel), .portId(portId),
    .readStrobe(readStrobe), .intAck(intAck), .readData(readData), .intReq(intReq)
  );

  function automatic logic [7:0] expByte(logic [7:0] id, logic act, logic [4:0] keys);
    return (id == ADDR) ? {act, 2'b00, keys} : 8'h00;
  endfunction

  function automatic logic [4:0] riseOf(logic [4:0] lvl, logic [4:0] prev);
    return lvl & ~prev;
  endfunction

  task automatic check(string req);
    logic [7:0] eb;
    eb = expByte(portId, mAct, mKeys);
    checks++;
    if (readData !== eb) begin
      errors++;
      $display("FAIL %s readData actual %02h expected %02h", req, readData, eb);
    end
    checks++;
    if (intReq !== mIrq) begin
      errors++;
      $display("FAIL %s intReq actual %0b expected %0b", req, intReq, mIrq);
    end
  endtask

  // Drive at negedge, advance model across posedge, check at next negedge
  // with the strobes already released but portId kept.
  task automatic step(logic [4:0] lvl, logic [7:0] id, logic rs, logic ak, string req);
    logic [4:0] r;
    keyLevel = lvl; portId = id; readStrobe = rs; intAck = ak;
    @(posedge clk);
    r = riseOf(lvl, mPrev);
    if (rst) begin
      mPrev = '1; mKeys = '0; mAct = 1'b0; mIrq = 1'b0;
    end else begin
      mPrev = lvl;
      if (r != '0) begin
        mKeys = r; mAct = 1'b1; mIrq = 1'b1;
      end else begin
        if ((rs && id == ADDR) || ak) mAct = 1'b0;
        if (ak) mIrq = 1'b0;
      end
    end
    @(negedge clk);
    readStrobe = 1'b0; intAck = 1'b0;
    check(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R9: Select held through reset
    keyLevel = 5'b10000; portId = ADDR;
    repeat (3) @(negedge clk);
    check("R1");
    rst = 1'b0;
    step(5'b10000, ADDR, 0, 0, "R9");
    step(5'b10000, ADDR, 0, 0, "R9");
    step(5'b00000, ADDR, 0, 0, "R1");
    // R2: press Up
    step(5'b00010, ADDR, 0, 0, "R2");
    // R3: hold, read clears, stays clear
    step(5'b00010, ADDR, 1, 0, "R4");
    step(5'b00010, ADDR, 0, 0, "R3");
    step(5'b00010, ADDR, 0, 0, "R3");
    // R10: release keeps mask; foreign read does nothing
    step(5'b00000, ADDR, 0, 0, "R10");
    step(5'b00000, 8'h21, 0, 0, "R7");
    step(5'b01000, 8'h21, 1, 0, "R10");
    step(5'b01000, ADDR, 0, 0, "R10");
    // R8: intReq survives a read, ack drops it
    step(5'b01000, ADDR, 1, 0, "R8");
    step(5'b01000, ADDR, 0, 1, "R8");
    // R6: press Left with a read
    step(5'b00100, ADDR, 1, 0, "R6");
    // R5: ack clears active
    step(5'b00100, ADDR, 0, 1, "R5");
    // R11: press Down and Right together with ack
    step(5'b01101, ADDR, 0, 1, "R11");
    step(5'b01101, ADDR, 0, 1, "R5");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] lvl;
      logic [7:0] id;
      lvl = keyLevel;
      if ($urandom_range(0, 5) == 0) lvl = 5'($urandom);
      id = ($urandom_range(0, 3) == 0) ? 8'($urandom) : ADDR;
      step(lvl, id, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) == 0), "R2");
    end
    // reset mid-run
    rst = 1'b1;
    step(5'b00000, ADDR, 0, 0, "R1");
    rst = 1'b0;
    step(5'b00000, ADDR, 0, 0, "R1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule